// File: doc/BRIEF.md
# Power domain switch sequencer

This block gates power to one switchable logic domain. It runs on the crystal reference clock and is programmed through a small register read/write port with two words. The first word is at byte offset 0x0 and holds the control fields and the power status. The second word is at byte offset 0x4 and holds the completion flags and a flop-retention enable. A power request comes from one of two places. In software mode it comes from a collapse bit. In hardware-trigger mode it comes from a dedicated input pin.

On a power-up request the sequencer first enables a small group of head switches and waits. It then enables the remaining switches and waits again. Next it releases the isolation clamp and the domain reset, and it lets the domain clock run a fixed number of cycles later. Power-down runs the same steps in reverse: it stops the clock, waits, clamps and holds the domain in reset, and then opens every switch. Each programmable wait is a power of two in reference-clock cycles.

The power status bit lags every change of request on purpose. A software override bypasses the timed steps altogether. A request that changes while a sequence is under way is acted on only after the sequence has reached a stable on or off state.

Top module: `pdom_seq`

## Requirements
- R1: After reset, word 0x0 reads 0x0028_2001 and word 0x4 reads 0x0000_8000. At the same time few_sw_en, rest_sw_en and retain_en are 0, and clamp_en, dom_rst and clk_off are 1.
- R2: Power-up follows a fixed order. few_sw_en rises one cycle after the request turns on. rest_sw_en rises 2^F cycles after few_sw_en. clamp_en and dom_rst fall together 2^R cycles after rest_sw_en. clk_off falls RESUME_CYC (4) cycles after that.
- R3: Power-down follows a fixed order. clk_off rises one cycle after the request turns off. clamp_en and dom_rst rise 2^C cycles later. Both switch enables drop one cycle after that.
- R4: Three 4-bit wait fields set the delays. Word 0x0 bits 23:20 give R, bits 19:16 give F and bits 15:12 give C.
- R5: Word 0x0 bit 31 reports the power status. It is 1 only when the domain is fully on. When the request changes, the bit keeps its old value for the next LAG_CYC+1 (9) cycles.
- R6: Word 0x4 bit 16 reads 1 when the domain is fully on, and bit 15 reads 1 when it is fully off. Bit 11 is writable, reads back, and drives retain_en.
- R7: Word 0x0 bit 0 is the collapse bit (1 = off). Bit 1 selects hardware-trigger mode. In that mode hw_req (1 = on) is the request and the collapse bit is ignored.
- R8: Entering or leaving hardware-trigger mode while the domain is not off forces a full power-down. The domain then powers up again if the request is on.
- R9: While override bit 2 is set, the outputs follow the collapse bit in the same cycle, with no waits. Collapse 0 gives both enables 1 and clamp, reset and clk_off 0. Collapse 1 gives the reverse.
- R10: A request change during a sequence does not cut the sequence short. The sequence runs to its stable state and only then turns around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte offset (0x0 or 0x4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| hw_req | input | 1 | Power request in hardware-trigger mode (1 = on) |
| few_sw_en | output | 1 | Enable for the first switch group |
| rest_sw_en | output | 1 | Enable for the remaining switches |
| clamp_en | output | 1 | Isolation clamp on domain outputs |
| dom_rst | output | 1 | Domain reset |
| clk_off | output | 1 | Domain clock disable |
| retain_en | output | 1 | Flop-retention enable |

## Verification
Two events can land in the same cycle. One is an opposite request reaching the sequencer. The other is the clock-resume wait expiring, which is the step that completes power-up. The bench provokes this by setting all waits to zero and timing a collapse write so that its clock edge is exactly the edge on which the sequence enters the on state. The run passes only if clk_off is low for exactly one cycle and the power-down steps then follow in order, which shows the late request was neither lost nor allowed to cut the sequence short.

// File: rtl/pdom_seq.sv
module pdom_seq #(
  parameter int LAG_CYC    = 8,
  parameter int RESUME_CYC = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_req,
  output logic              few_sw_en,
  output logic              rest_sw_en,
  output logic              clamp_en,
  output logic              dom_rst,
  output logic              clk_off,
  output logic              retain_en
);
  localparam int FW    = 4;
  localparam int CNT_W = 1 << FW;
  localparam int LAG_W = $clog2(LAG_CYC + 1);

  typedef enum logic [2:0] {S_OFF, S_FEW, S_REST, S_REL, S_ON, S_CKD, S_CLP} st_t;

  logic          coll, hwm, ovr, retain;
  logic [FW-1:0] w_rest, w_few, w_ckd;
  st_t           st;
  logic [CNT_W-1:0] cnt;
  logic          want, want_q, mode_q, force_cyc;
  logic [LAG_W-1:0] lag;
  logic          stat;

  wire wr0 = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
  wire wr1 = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));

  function automatic logic [CNT_W-1:0] span(input logic [FW-1:0] n);
    return (CNT_W'(1) << n) - CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll   <= 1'b1;
      hwm    <= 1'b0;
      ovr    <= 1'b0;
      w_rest <= FW'(2);
      w_few  <= FW'(8);
      w_ckd  <= FW'(2);
      retain <= 1'b0;
    end else begin
      if (wr0) begin
        coll   <= bus_wdata[0];
        hwm    <= bus_wdata[1];
        ovr    <= bus_wdata[2];
        w_ckd  <= bus_wdata[15:12];
        w_few  <= bus_wdata[19:16];
        w_rest <= bus_wdata[23:20];
      end
      if (wr1) retain <= bus_wdata[11];
    end
  end

  assign want = hwm ? hw_req : ~coll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      force_cyc <= 1'b0;
    end else begin
      mode_q <= hwm;
      if (hwm != mode_q && st != S_OFF) force_cyc <= 1'b1;
      else if (st == S_OFF)             force_cyc <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else if (ovr) begin
      st  <= coll ? S_OFF : S_ON;
      cnt <= '0;
    end else begin
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      case (st)
        S_OFF:  if (want && !force_cyc) begin st <= S_FEW; cnt <= span(w_few); end
        S_FEW:  if (cnt == '0) begin st <= S_REST; cnt <= span(w_rest); end
        S_REST: if (cnt == '0) begin st <= S_REL; cnt <= CNT_W'(RESUME_CYC - 1); end
        S_REL:  if (cnt == '0) st <= S_ON;
        S_ON:   if (!want || force_cyc) begin st <= S_CKD; cnt <= span(w_ckd); end
        S_CKD:  if (cnt == '0) st <= S_CLP;
        S_CLP:  st <= S_OFF;
        default: st <= S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      lag    <= '0;
      stat   <= 1'b0;
    end else begin
      want_q <= want;
      if (want != want_q)  lag  <= LAG_W'(LAG_CYC);
      else if (lag != '0)  lag  <= lag - LAG_W'(1);
      else                 stat <= (st == S_ON);
    end
  end

  wire f_few   = (st != S_OFF);
  wire f_rest  = (st == S_REST) || (st == S_REL) || (st == S_ON) || (st == S_CKD) || (st == S_CLP);
  wire f_clamp = (st == S_OFF) || (st == S_FEW) || (st == S_REST) || (st == S_CLP);

  assign few_sw_en  = ovr ? ~coll : f_few;
  assign rest_sw_en = ovr ? ~coll : f_rest;
  assign clamp_en   = ovr ? coll  : f_clamp;
  assign dom_rst    = ovr ? coll  : f_clamp;
  assign clk_off    = ovr ? coll  : (st != S_ON);
  assign retain_en  = retain;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(0))
      bus_rdata = {stat, 7'b0, w_rest, w_few, w_ckd, 9'b0, ovr, hwm, coll};
    else if (bus_addr == ADDR_W'(4))
      bus_rdata = {15'b0, st == S_ON, st == S_OFF, 3'b0, retain, 11'b0};
  end
endmodule

// File: rtl/pdom_seq_chk.sv
module pdom_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ovr,
  input logic coll,
  input logic want,
  input logic stat,
  input logic few_sw_en,
  input logic rest_sw_en,
  input logic clamp_en,
  input logic dom_rst,
  input logic clk_off
);
  AST_REST_AFTER_FEW: assert property (@(posedge clk) disable iff (!rst_n)
    rest_sw_en |-> few_sw_en); // R2
  AST_CLK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_off |-> (rest_sw_en && !clamp_en && !dom_rst)); // R2
  AST_OFF_IS_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    !few_sw_en |-> (clamp_en && dom_rst)); // R3
  AST_CLAMP_BEFORE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(few_sw_en) && !ovr && !$past(ovr)) |-> $past(clamp_en)); // R3
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (want != $past(want)) |=> $stable(stat)); // R5
  AST_OVERRIDE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> ((few_sw_en == !coll) && (clk_off == coll))); // R9
endmodule

bind pdom_seq pdom_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovr(ovr), .coll(coll), .want(want), .stat(stat),
  .few_sw_en(few_sw_en), .rest_sw_en(rest_sw_en), .clamp_en(clamp_en),
  .dom_rst(dom_rst), .clk_off(clk_off)
);

// File: tb/sim_pdom_seq.sv
`timescale 1ns/1ps
module sim_pdom_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, hw_req = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic few_sw_en, rest_sw_en, clamp_en, dom_rst, clk_off, retain_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pdom_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_req(hw_req), .few_sw_en(few_sw_en), .rest_sw_en(rest_sw_en),
    .clamp_en(clamp_en), .dom_rst(dom_rst), .clk_off(clk_off), .retain_en(retain_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = '0;
  endtask

  function automatic logic [4:0] outs();
    return {few_sw_en, rest_sw_en, clamp_en, dom_rst, clk_off};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 word0", d, 32'h0028_2001);
    rd(4'h4, d); chk("R1 word4", d, 32'h0000_8000);
    chk("R1 outputs", {27'b0, outs()}, {27'b0, 5'b00111});
    chk("R1 retain", {31'b0, retain_en}, 32'd0);
  endtask

  task automatic t_powerup();
    wr(4'h0, 32'h0021_1000);
    chk("R2 few before", {31'b0, few_sw_en}, 0);
    step(1); chk("R2 few on", {27'b0, outs()}, {27'b0, 5'b10111});
    step(1); chk("R4 rest waits 2^1", {31'b0, rest_sw_en}, 0);
    step(1); chk("R2 rest on", {27'b0, outs()}, {27'b0, 5'b11111});
    step(3); chk("R4 clamp waits 2^2", {31'b0, clamp_en}, 1);
    step(1); chk("R2 clamp/reset released", {27'b0, outs()}, {27'b0, 5'b11001});
    step(3); chk("R2 clock still off", {31'b0, clk_off}, 1);
    step(1); chk("R2 clock on", {27'b0, outs()}, {27'b0, 5'b11000});
  endtask

  task automatic t_powerdown();
    wr(4'h0, 32'h0021_1001);
    step(1); chk("R3 clock off first", {27'b0, outs()}, {27'b0, 5'b11001});
    step(1); chk("R3 clamp waits 2^1", {31'b0, clamp_en}, 0);
    step(1); chk("R3 clamp+reset", {27'b0, outs()}, {27'b0, 5'b11111});
    step(1); chk("R3 switches open", {27'b0, outs()}, {27'b0, 5'b00111});
    step(20);
  endtask

  task automatic t_lag();
    logic [31:0] d;
    wr(4'h0, 32'h0000_0000);
    step(8);
    rd(4'h4, d); chk("R6 up-complete", d[16], 1);
    rd(4'h0, d); chk("R5 status lags", d[31], 0);
    step(2);
    rd(4'h0, d); chk("R5 status on", d[31], 1);
    wr(4'h0, 32'h0000_0001);
    step(4);
    rd(4'h4, d); chk("R6 down-complete", d[15], 1);
    rd(4'h0, d); chk("R5 status holds on", d[31], 1);
    step(8);
    rd(4'h0, d); chk("R5 status off", d[31], 0);
    step(10);
  endtask

  task automatic t_held();
    wr(4'h0, 32'h0003_0000);
    step(2);
    wr(4'h0, 32'h0003_0001);
    step(5); chk("R10 rest still pending", {31'b0, rest_sw_en}, 0);
    step(1); chk("R10 rest on after collapse", {31'b0, rest_sw_en}, 1);
    step(5); chk("R10 reaches on", {31'b0, clk_off}, 0);
    step(3); chk("R10 then off", {31'b0, few_sw_en}, 0);
    step(20);
  endtask

  task automatic t_race();
    wr(4'h0, 32'h0000_0000);
    step(6);
    wr(4'h0, 32'h0000_0001);
    chk("R10 on at same edge as collapse", {31'b0, clk_off}, 0);
    step(1); chk("R3 immediate clock stop", {31'b0, clk_off}, 1);
    step(1); chk("R3 clamp follows", {31'b0, clamp_en}, 1);
    step(1); chk("R3 open after race", {31'b0, few_sw_en}, 0);
    step(20);
  endtask

  task automatic t_hwmode();
    bit saw_off = 0;
    hw_req = 1'b1;
    wr(4'h0, 32'h0000_0000);
    step(15); chk("R7 sw on", {31'b0, clk_off}, 0);
    wr(4'h0, 32'h0000_0002);
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (!few_sw_en) saw_off = 1;
    end
    chk("R8 power cycle on mode entry", {31'b0, saw_off}, 1);
    chk("R8 back on", {31'b0, clk_off}, 0);
    hw_req = 1'b0;
    step(12); chk("R7 hw_req off ignores collapse", {31'b0, few_sw_en}, 0);
    wr(4'h0, 32'h0000_0001);
    step(20); chk("R7 stays off", {31'b0, few_sw_en}, 0);
  endtask

  task automatic t_override();
    wr(4'h0, 32'h0000_0004);
    chk("R9 override on", {27'b0, outs()}, {27'b0, 5'b11000});
    wr(4'h0, 32'h0000_0005);
    chk("R9 override off", {27'b0, outs()}, {27'b0, 5'b00111});
    wr(4'h0, 32'h0000_0001);
    step(3); chk("R9 exit stays off", {31'b0, few_sw_en}, 0);
  endtask

  task automatic t_retain();
    logic [31:0] d;
    wr(4'h4, 32'h0000_0800);
    rd(4'h4, d); chk("R6 retain readback", d[11], 1);
    chk("R6 retain pin", {31'b0, retain_en}, 1);
    wr(4'h4, 32'h0000_0000);
    chk("R6 retain cleared", {31'b0, retain_en}, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_powerup();
    t_powerdown();
    t_lag();
    t_held();
    t_race();
    t_hwmode();
    t_override();
    t_retain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule